// File: doc/BRIEF.md
# Serial Shift-In Reader

This controller reads a byte from an external parallel-in, serial-out shift register. Each read cycle opens with a pulse on the active-low load line, which captures the register's parallel inputs. The load line then returns high, which freezes the captured data and allows shifting. The controller reads the serial data line, then pulses the shift clock low and back high so that the rising edge presents the next bit. It does this eight times. The first bit is taken straight after the load, before any clock pulse.

The bits are collected most significant first. When the eighth bit and its clock pulse are done, the completed byte is presented for exactly one clock together with a valid strobe. The controller then waits a parameterised idle interval. After that it starts a new cycle whenever `enable` is high.

The byte output has no back-pressure. The consumer must take `rx_data` in the single cycle where `rx_valid` is high. The next byte cannot come sooner than the idle interval plus one full read cycle. `enable` is a plain level input: clearing it stops new cycles from starting, but it does not cut short a cycle already in progress.

Top module: `shreg_reader`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `load_n` and `sck` are high and `rx_valid` is low. Asserting reset in the middle of a cycle returns all three to these values at once.
- R2: Each read cycle starts with `load_n` low for exactly LOAD_CYC consecutive system clocks.
- R3: The first bit is sampled after the load line returns high and before any falling edge of `sck`. A value on the external register's serial input therefore never reaches the result.
- R4: Each read cycle produces exactly NBITS (8) falling edges of `sck`. Each low phase of `sck` lasts exactly CLKLO_CYC clocks.
- R5: The first sampled bit lands in bit 7 of `rx_data`, and each later bit lands one position lower, down to bit 0.
- R6: `rx_valid` is high for exactly one clock per read cycle, and `rx_data` holds the assembled byte in that clock.
- R7: With `enable` held high, `load_n` falls exactly IDLE_CYC clocks after the clock in which `rx_valid` was high.
- R8: While `enable` is low, no new cycle starts. Clearing `enable` after a cycle has begun still lets that cycle deliver its byte.
- R9: `load_n` and `sck` are never low in the same clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Allows new read cycles to start |
| sdata | input | 1 | Serial data from the external register |
| load_n | output | 1 | Active-low parallel load strobe |
| sck | output | 1 | Shift clock, idles high |
| rx_data | output | NBITS | Assembled byte, MSB first |
| rx_valid | output | 1 | One-cycle strobe qualifying `rx_data` |

## Verification
The bench models the external register: parallel capture while `load_n` is low, and a shift on each rising edge of `sck`. It then reads a table of parallel patterns, each with its own level on the model's serial input.

- All-zeros with the serial input at one separates sampling before the clock from sampling after it.
- The single-bit patterns 0x80 and 0x01 expose a reversed bit order.
- All-ones, 0xA5 and 0x3C catch stuck or swapped bits.

Directed runs then cover the enable gating, dropping enable in mid-cycle, and reset in mid-shift.

// File: rtl/shrd_pkg.sv
package shrd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_SETTLE,
    ST_CLO,
    ST_CHI
  } rd_state_e;

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/shrd_timer.sv
module shrd_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/shrd_collect.sv
module shrd_collect #(
  parameter int NBITS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             shift,
  input  logic             sin,
  output logic [NBITS-1:0] word,
  output logic             full
);
  localparam int NW = $clog2(NBITS + 1);

  logic [NW-1:0]    n_q;
  logic [NBITS-1:0] w_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_q <= '0;
      w_q <= '0;
    end else if (clear) begin
      n_q <= '0;
    end else if (shift) begin
      n_q <= n_q + 1'b1;
      w_q <= {w_q[NBITS-2:0], sin};
    end
  end

  assign word = w_q;
  assign full = (n_q == NW'(NBITS));
endmodule

// File: rtl/shreg_reader.sv
module shreg_reader
  import shrd_pkg::*;
#(
  parameter int NBITS      = 8,
  parameter int LOAD_CYC   = 4,
  parameter int SETTLE_CYC = 4,
  parameter int CLKLO_CYC  = 4,
  parameter int CLKHI_CYC  = 4,
  parameter int IDLE_CYC   = 1000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             sdata,
  output logic             load_n,
  output logic             sck,
  output logic [NBITS-1:0] rx_data,
  output logic             rx_valid
);
  localparam int MAXD = max_of(max_of(max_of(LOAD_CYC, SETTLE_CYC),
                                      max_of(CLKLO_CYC, CLKHI_CYC)), IDLE_CYC);
  localparam int CW   = $clog2(MAXD + 1);

  rd_state_e        ps, ns;
  logic             t_load, t_exp;
  logic [CW-1:0]    t_val;
  logic             c_clear, c_shift, c_full, fin;
  logic [NBITS-1:0] c_word;

  shrd_timer #(.CW(CW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val), .expired(t_exp)
  );

  shrd_collect #(.NBITS(NBITS)) u_col (
    .clk(clk), .rst_n(rst_n), .clear(c_clear), .shift(c_shift),
    .sin(sdata), .word(c_word), .full(c_full)
  );

  always_comb begin
    ns      = ps;
    t_load  = 1'b0;
    t_val   = '0;
    c_clear = 1'b0;
    c_shift = 1'b0;
    fin     = 1'b0;
    unique case (ps)
      ST_IDLE: if (t_exp && enable) begin
        ns = ST_LOAD; t_load = 1'b1; t_val = CW'(LOAD_CYC - 1); c_clear = 1'b1;
      end
      ST_LOAD: if (t_exp) begin
        ns = ST_SETTLE; t_load = 1'b1; t_val = CW'(SETTLE_CYC - 1);
      end
      ST_SETTLE: if (t_exp) begin
        c_shift = 1'b1;
        ns = ST_CLO; t_load = 1'b1; t_val = CW'(CLKLO_CYC - 1);
      end
      ST_CLO: if (t_exp) begin
        ns = ST_CHI; t_load = 1'b1; t_val = CW'(CLKHI_CYC - 1);
      end
      ST_CHI: if (t_exp) begin
        t_load = 1'b1;
        if (c_full) begin
          ns = ST_IDLE; t_val = CW'(IDLE_CYC - 1); fin = 1'b1;
        end else begin
          ns = ST_SETTLE; t_val = CW'(SETTLE_CYC - 1);
        end
      end
      default: ns = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ps       <= ST_IDLE;
      load_n   <= 1'b1;
      sck      <= 1'b1;
      rx_valid <= 1'b0;
      rx_data  <= '0;
    end else begin
      ps       <= ns;
      load_n   <= (ns != ST_LOAD);
      sck      <= (ns != ST_CLO);
      rx_valid <= fin;
      if (fin) rx_data <= c_word;
    end
  end
endmodule

// File: rtl/shreg_reader_chk.sv
module shreg_reader_chk #(
  parameter int NBITS     = 8,
  parameter int LOAD_CYC  = 4,
  parameter int CLKLO_CYC = 4,
  parameter int IDLE_CYC  = 1000
) (
  input logic clk,
  input logic rst_n,
  input logic load_n,
  input logic sck,
  input logic rx_valid
);
  logic [15:0] ld_run, lo_run, falls, since_v;
  logic        sck_d, seen_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_run <= '0; lo_run <= '0; falls <= '0; since_v <= '0;
      sck_d  <= 1'b1; seen_v <= 1'b0;
    end else begin
      sck_d  <= sck;
      ld_run <= load_n ? 16'd0 : ld_run + 16'd1;
      lo_run <= sck    ? 16'd0 : lo_run + 16'd1;
      if (!load_n)              falls <= '0;
      else if (sck_d && !sck)   falls <= falls + 16'd1;
      if (rx_valid) begin
        seen_v  <= 1'b1;
        since_v <= 16'd1;
      end else if (since_v != 16'hFFFF) begin
        since_v <= since_v + 16'd1;
      end
    end
  end

  // R9
  p_no_overlap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(!load_n && !sck));
  // R6
  p_valid_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  // R2
  p_load_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && ld_run != 16'd0) |-> (32'(ld_run) == LOAD_CYC));
  // R4
  p_low_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sck && lo_run != 16'd0) |-> (32'(lo_run) == CLKLO_CYC));
  // R4
  p_eight_falls_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> (32'(falls) == NBITS));
  // R7
  p_idle_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_v && !load_n && ld_run == 16'd0) |-> (32'(since_v) >= IDLE_CYC));
endmodule

bind shreg_reader shreg_reader_chk #(
  .NBITS(NBITS), .LOAD_CYC(LOAD_CYC), .CLKLO_CYC(CLKLO_CYC), .IDLE_CYC(IDLE_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .load_n(load_n), .sck(sck), .rx_valid(rx_valid)
);

// File: tb/sim_shreg_reader.sv
`timescale 1ns/1ps
module sim_shreg_reader;
  localparam int LOAD = 2, SETTLE = 2, CLO = 2, CHI = 3, IDLE = 20;
  localparam int NV = 6;
  // {serial-in level, parallel pattern, expected byte}
  localparam logic [16:0] VEC [NV] = '{
    {1'b1, 8'h00, 8'h00},   // R3
    {1'b0, 8'hFF, 8'hFF},
    {1'b0, 8'h80, 8'h80},   // R5
    {1'b0, 8'h01, 8'h01},   // R5
    {1'b1, 8'hA5, 8'hA5},
    {1'b0, 8'h3C, 8'h3C}
  };

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0;
  logic load_n, sck, sdata, rx_valid;
  logic [7:0] rx_data;
  logic [7:0] par = 8'h00, sr = 8'h00;
  logic ser_in = 1'b0;
  int nchk = 0, nfail = 0, cyc = 0, lf = 0;
  int t_valid = 0;
  bit have_prev = 1'b0;
  logic ld_prev = 1'b1;

  always #10 clk = ~clk;
  always @(posedge clk) cyc++;

  always @(posedge sck or negedge load_n)
    if (!load_n) sr <= par;
    else         sr <= {sr[6:0], ser_in};
  assign sdata = sr[7];

  always @(negedge clk) begin
    if (ld_prev === 1'b1 && load_n === 1'b0) lf++;
    ld_prev = load_n;
  end

  shreg_reader #(
    .NBITS(8), .LOAD_CYC(LOAD), .SETTLE_CYC(SETTLE),
    .CLKLO_CYC(CLO), .CLKHI_CYC(CHI), .IDLE_CYC(IDLE)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .enable(en), .sdata(sdata),
    .load_n(load_n), .sck(sck), .rx_data(rx_data), .rx_valid(rx_valid)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_cycle(input logic [7:0] pv, input logic sv,
                          input logic [7:0] ev, input bit drop_en);
    int guard, lw, falls;
    logic prev;
    par = pv; ser_in = sv;
    guard = 0;
    while (load_n !== 1'b0) begin
      @(negedge clk); guard++;
      if (guard > 5000) begin chk(0, "R2 load start", 0, 1); return; end
    end
    if (have_prev) chk(cyc - t_valid == IDLE, "R7 idle gap", cyc - t_valid, IDLE);
    if (drop_en) en = 1'b0;
    lw = 0;
    while (load_n === 1'b0) begin lw++; @(negedge clk); end
    chk(lw == LOAD, "R2 load width", lw, LOAD);
    falls = 0; prev = sck; guard = 0;
    while (rx_valid !== 1'b1) begin
      @(negedge clk); guard++;
      if (prev === 1'b1 && sck === 1'b0) falls++;
      prev = sck;
      if (guard > 5000) begin chk(0, "R6 valid timeout", 0, 1); return; end
    end
    t_valid = cyc;
    have_prev = !drop_en;
    chk(falls == 8, "R4 sck falls", falls, 8);
    chk(rx_data == ev, "R3/R5 byte", rx_data, ev);
    @(negedge clk);
    chk(rx_valid === 1'b0, "R6 single pulse", rx_valid, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    int lf0, guard;
    repeat (3) @(negedge clk);
    chk(load_n === 1'b1, "R1 load_n in reset", load_n, 1);
    chk(sck === 1'b1, "R1 sck in reset", sck, 1);
    chk(rx_valid === 1'b0, "R1 valid in reset", rx_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(load_n === 1'b1 && sck === 1'b1, "R1 after release", {load_n, sck}, 3);
    repeat (40) @(negedge clk);
    chk(lf == 0, "R8 enable low holds", lf, 0);

    en = 1'b1;
    for (int i = 0; i < NV; i++)
      do_cycle(VEC[i][15:8], VEC[i][16], VEC[i][7:0], 1'b0);

    // R8: enable dropped after cycle began still delivers
    do_cycle(8'h5A, 1'b1, 8'h5A, 1'b1);
    lf0 = lf;
    repeat (3 * IDLE) @(negedge clk);
    chk(lf == lf0, "R8 no restart while disabled", lf - lf0, 0);
    en = 1'b1;
    do_cycle(8'hC3, 1'b0, 8'hC3, 1'b0);

    // R1: reset mid-shift
    guard = 0;
    while (sck !== 1'b0 && guard < 5000) begin @(negedge clk); guard++; end
    rst_n = 1'b0;
    @(negedge clk);
    chk(load_n === 1'b1 && sck === 1'b1 && rx_valid === 1'b0,
        "R1 mid-cycle reset", {load_n, sck, rx_valid}, 6);
    rst_n = 1'b1;
    have_prev = 1'b0;
    do_cycle(8'h96, 1'b1, 8'h96, 1'b0);
    do_cycle(8'h69, 1'b0, 8'h69, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule